// File: doc/BRIEF.md
# Received Byte Buffer with Serial Host Readout

This block sits behind a modem's bit demodulator. Each received bit arrives with its bit clock. Once the block has been armed by a frame match, it packs the bits into bytes. When a byte is complete, an active-low pin tells the host that data is waiting. The host then clocks the byte out over a serial line with eight clocks of its own. Bytes keep flowing this way for as long as the stream lasts, and the host never has to re-arm the block between them.

The same active-low pin also serves two other receive modes. In raw mode it carries every demodulated bit directly, and those bits change in step with a buffered copy of the bit clock. In stop mode the pin is held high and the bit clock output is released. A frame-armed control bit sets itself on every frame match. The host cannot clear it while a byte is still waiting to be read. A clear written with the direction input high also wipes the partial byte, and the block then waits for the next frame.

Top module: `rx_byte_reader`

## Requirements
- R1: After reset, `readyDataN`, `sdo` and `bitClkOe` are 1, while `frameArmed` and `overrun` are 0. The mode is framed (`cfgMode` = 00).
- R2: Framed mode is `cfgMode[1]`=0. In this mode, while armed, the block samples `rxBit` on each rising edge of `rxBitClk`. The first bit received becomes bit 7 of the byte. After the eighth bit, `readyDataN` goes low.
- R3: Before the first host clock, `sdo` already shows byte bit 7. Each falling edge of `hostSclk` moves `sdo` on to the next lower bit. The edge takes effect within four system clocks, because it passes a two-stage synchronizer first. After the eighth falling edge, `readyDataN` returns high and `sdo` idles at 1.
- R4: Later bytes become ready and are read in the same way, with no further arming.
- R5: A `frameHit` pulse in framed mode sets `frameArmed` and restarts byte alignment. Bits received while the block is not armed are dropped.
- R6: While a byte is waiting, a write with `cfgFrameClr`=0 leaves `frameArmed` at 1.
- R7: An accepted clear written with `hostDir`=1 clears `frameArmed`, discards any partly assembled byte and clears `overrun`.
- R8: An accepted clear written with `hostDir`=0 only disarms the block. The partial byte is kept, and it resumes when the block is re-armed by a write with `cfgFrameClr`=1.
- R9: Raw mode is `cfgMode`=10. In this mode `readyDataN` carries each received bit, updated on the falling edge of `bitClkOut`, which follows `rxBitClk`.
- R10: Stop mode is `cfgMode`=11. In this mode `readyDataN` stays 1, `bitClkOe` is 0, and no bits are assembled.
- R11: If a byte completes while the previous byte is still waiting, the new byte replaces it and the readout restarts at bit 7. `overrun` then sets and stays set until the next reinitializing clear (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxBit | input | 1 | Demodulated receive bit |
| rxBitClk | input | 1 | Receive bit clock, synchronous to clk |
| frameHit | input | 1 | One-cycle frame match pulse |
| hostSclk | input | 1 | Host serial read clock, asynchronous |
| hostDir | input | 1 | Direction input; qualifies reinitializing clears |
| cfgWe | input | 1 | Control write strobe |
| cfgFrameClr | input | 1 | Written frame-armed value |
| cfgMode | input | 2 | Written receive mode |
| readyDataN | output | 1 | Byte-ready flag (active low) or raw data |
| sdo | output | 1 | Serial read data |
| bitClkOut | output | 1 | Buffered receive bit clock |
| bitClkOe | output | 1 | Output enable for bitClkOut |
| frameArmed | output | 1 | Frame-armed control bit |
| overrun | output | 1 | Sticky overrun status |

## Verification
The assertions check several rules on every cycle:
- `sdo` idles high whenever no byte is waiting.
- A pending byte keeps `frameArmed` set against any host write.
- A frame match arms the block in framed mode.
- Stop mode forces its pin levels.
- `overrun` only leaves 1 through a reinitializing write.

Other behaviours need the bench's scenarios to show them: the bit ordering of assembled and shifted bytes, the restart of alignment, the difference between the two kinds of clear, the timing of raw bits against the bit clock, and the byte that survives an overrun.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [1:0] {
    MODE_FRAMED_A = 2'b00,
    MODE_FRAMED_B = 2'b01,
    MODE_RAW      = 2'b10,
    MODE_STOP     = 2'b11
  } rxMode_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic bitShift;    // shift rxBit into the assembly register
    logic byteLoad;    // move finished byte into the readout register
    logic rdShift;     // advance readout by one bit
    logic reinit;      // force assembly register to all ones
    logic rawCapture;  // sample rxBit for raw output
    logic rawPresent;  // present sampled raw bit on the flag pin
  } ctrlStb_t;

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxBitClk,
  input  logic       frameHit,
  input  logic       hostSclk,
  input  logic       hostDir,
  input  logic       cfgWe,
  input  logic       cfgFrameClr,
  input  logic [1:0] cfgMode,
  output ctrlStb_t   stb,
  output rxMode_e    modeQ,
  output logic       readyPend,
  output logic       frameArmed,
  output logic       overrun,
  output logic       bitClkQ
);

  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES:0] sclkPipe;
  logic [CNT_W-1:0]     bitCnt;
  logic [CNT_W-1:0]     rdCnt;

  logic framed, hitNow, rxRise, rxFall, sclkFall, rdLast, clearOk;

  // Synchronizer stages plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclkPipe <= '0;
    else        sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], hostSclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bitClkQ <= 1'b0;
    else        bitClkQ <= rxBitClk;
  end

  always_comb begin
    framed   = (modeQ == MODE_FRAMED_A) || (modeQ == MODE_FRAMED_B);
    hitNow   = frameHit && framed;
    rxRise   = rxBitClk && !bitClkQ;
    rxFall   = !rxBitClk && bitClkQ;
    sclkFall = sclkPipe[SYNC_STAGES] && !sclkPipe[SYNC_STAGES-1];
    clearOk  = cfgWe && !cfgFrameClr && !readyPend;

    stb.bitShift   = framed && frameArmed && rxRise && !hitNow;
    stb.byteLoad   = stb.bitShift && (bitCnt == LAST_IDX);
    stb.rdShift    = sclkFall && readyPend;
    stb.reinit     = clearOk && hostDir && !hitNow;
    stb.rawCapture = (modeQ == MODE_RAW) && rxRise;
    stb.rawPresent = (modeQ == MODE_RAW) && rxFall;
    rdLast         = stb.rdShift && (rdCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     modeQ <= MODE_FRAMED_A;
    else if (cfgWe) modeQ <= rxMode_e'(cfgMode);
  end

  // Frame match wins over host writes; clears are blocked while a byte waits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    frameArmed <= 1'b0;
    else if (hitNow)               frameArmed <= 1'b1;
    else if (cfgWe && cfgFrameClr) frameArmed <= 1'b1;
    else if (clearOk)              frameArmed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bitCnt <= '0;
    else if (hitNow || stb.reinit)   bitCnt <= '0;
    else if (stb.byteLoad)           bitCnt <= '0;
    else if (stb.bitShift)           bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyPend <= 1'b0;
      rdCnt     <= '0;
    end else if (stb.byteLoad) begin
      readyPend <= 1'b1;
      rdCnt     <= '0;
    end else if (rdLast) begin
      readyPend <= 1'b0;
      rdCnt     <= '0;
    end else if (stb.rdShift) begin
      rdCnt     <= rdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  overrun <= 1'b0;
    else if (stb.reinit)                         overrun <= 1'b0;
    else if (stb.byteLoad && readyPend && !rdLast) overrun <= 1'b1;
  end

endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rxBit,
  input  ctrlStb_t stb,
  input  rxMode_e  modeQ,
  input  logic     readyPend,
  input  logic     bitClkQ,
  output logic     readyDataN,
  output logic     sdo,
  output logic     bitClkOut,
  output logic     bitClkOe
);

  logic [BYTE_W-1:0] asmReg;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] nextAsm;
  logic              rawHold;
  logic              rawBit;

  assign nextAsm = {asmReg[BYTE_W-2:0], rxBit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            asmReg <= '1;
    else if (stb.reinit)   asmReg <= '1;
    else if (stb.bitShift) asmReg <= nextAsm;
  end

  // New byte takes priority over an in-flight readout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shReg <= '1;
    else if (stb.byteLoad) shReg <= nextAsm;
    else if (stb.rdShift)  shReg <= {shReg[BYTE_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawHold <= 1'b1;
      rawBit  <= 1'b1;
    end else begin
      if (stb.rawCapture) rawHold <= rxBit;
      if (stb.rawPresent) rawBit  <= rawHold;
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_RAW:  readyDataN = rawBit;
      MODE_STOP: readyDataN = 1'b1;
      default:   readyDataN = !readyPend;
    endcase
    sdo       = readyPend ? shReg[BYTE_W-1] : 1'b1;
    bitClkOut = bitClkQ;
    bitClkOe  = (modeQ != MODE_STOP);
  end

endmodule

// File: rtl/rx_byte_reader.sv
module rx_byte_reader
  import rxbuf_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxBit,
  input  logic       rxBitClk,
  input  logic       frameHit,
  input  logic       hostSclk,
  input  logic       hostDir,
  input  logic       cfgWe,
  input  logic       cfgFrameClr,
  input  logic [1:0] cfgMode,
  output logic       readyDataN,
  output logic       sdo,
  output logic       bitClkOut,
  output logic       bitClkOe,
  output logic       frameArmed,
  output logic       overrun
);

  ctrlStb_t stb;
  rxMode_e  modeQ;
  logic     readyPend;
  logic     bitClkQ;

  rxbuf_ctrl #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxBitClk(rxBitClk), .frameHit(frameHit),
    .hostSclk(hostSclk), .hostDir(hostDir), .cfgWe(cfgWe),
    .cfgFrameClr(cfgFrameClr), .cfgMode(cfgMode), .stb(stb), .modeQ(modeQ),
    .readyPend(readyPend), .frameArmed(frameArmed), .overrun(overrun),
    .bitClkQ(bitClkQ)
  );

  rxbuf_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit), .stb(stb), .modeQ(modeQ),
    .readyPend(readyPend), .bitClkQ(bitClkQ), .readyDataN(readyDataN),
    .sdo(sdo), .bitClkOut(bitClkOut), .bitClkOe(bitClkOe)
  );

endmodule

// File: rtl/rx_byte_reader_chk.sv
module rx_byte_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfgWe,
  input logic       cfgFrameClr,
  input logic       hostDir,
  input logic       frameHit,
  input logic [1:0] modeQ,
  input logic       readyPend,
  input logic       readyDataN,
  input logic       sdo,
  input logic       bitClkOe,
  input logic       frameArmed,
  input logic       overrun
);

  p_sdo_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !readyPend |-> sdo);

  p_clear_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (readyPend && frameArmed && cfgWe) |=> frameArmed);

  p_hit_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frameHit && !modeQ[1]) |=> frameArmed);

  p_stop_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == 2'b11) |-> (readyDataN && !bitClkOe));

  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(cfgWe && !cfgFrameClr && hostDir)) |=> overrun);

endmodule

bind rx_byte_reader rx_byte_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgFrameClr(cfgFrameClr),
  .hostDir(hostDir), .frameHit(frameHit), .modeQ(modeQ),
  .readyPend(readyPend), .readyDataN(readyDataN), .sdo(sdo),
  .bitClkOe(bitClkOe), .frameArmed(frameArmed), .overrun(overrun)
);

// File: tb/rx_byte_reader_tb.sv
module rx_byte_reader_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxBit = 1'b0, rxBitClk = 1'b0, frameHit = 1'b0, hostSclk = 1'b0;
  logic hostDir = 1'b0, cfgWe = 1'b0, cfgFrameClr = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic readyDataN, sdo, bitClkOut, bitClkOe, frameArmed, overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_reader u_dut (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit), .rxBitClk(rxBitClk),
    .frameHit(frameHit), .hostSclk(hostSclk), .hostDir(hostDir),
    .cfgWe(cfgWe), .cfgFrameClr(cfgFrameClr), .cfgMode(cfgMode),
    .readyDataN(readyDataN), .sdo(sdo), .bitClkOut(bitClkOut),
    .bitClkOe(bitClkOe), .frameArmed(frameArmed), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxBit = b; rxBitClk = 1'b1;
    repeat (3) @(negedge clk);
    rxBitClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic pulseHit();
    @(negedge clk); frameHit = 1'b1;
    @(negedge clk); frameHit = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] m, input logic clr, input logic dir);
    @(negedge clk); cfgWe = 1'b1; cfgMode = m; cfgFrameClr = clr; hostDir = dir;
    @(negedge clk); cfgWe = 1'b0; hostDir = 1'b0;
    @(negedge clk);
  endtask

  task automatic readByte(output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      hostSclk = 1'b1;
      repeat (5) @(negedge clk);
      got[i] = sdo;
      hostSclk = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] v;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(readyDataN == 1'b1, "R1 flag", readyDataN, 1);
    check(sdo == 1'b1, "R1 sdo", sdo, 1);
    check(frameArmed == 1'b0, "R1 armed", frameArmed, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(bitClkOe == 1'b1, "R1 oe", bitClkOe, 1);

    // R5 bits ignored while disarmed
    sendBits(8'hA5, 8);
    check(readyDataN == 1'b1, "R5 disarmed flag", readyDataN, 1);
    pulseHit();
    check(frameArmed == 1'b1, "R5 armed by hit", frameArmed, 1);

    // R2 R3 R4 sweep of byte values, no re-arming
    for (int k = 0; k < 18; k++) begin
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + 5) % 256);
      sendBits(v, 8);
      check(readyDataN == 1'b0, k == 0 ? "R2 flag low" : "R4 flag low", readyDataN, 0);
      check(sdo == v[7], "R3 first bit before clocks", sdo, v[7]);
      readByte(got);
      check(got == v, "R3 byte readout", got, v);
      check(readyDataN == 1'b1, "R3 flag high after read", readyDataN, 1);
      check(sdo == 1'b1, "R3 sdo idle", sdo, 1);
    end

    // R5 realignment mid-byte
    sendBits(8'h0B, 4);
    pulseHit();
    sendBits(8'h6E, 8);
    readByte(got);
    check(got == 8'h6E, "R5 realign", got, 8'h6E);

    // R6 clear ignored while pending
    sendBits(8'h3C, 8);
    cfgWrite(2'b00, 1'b0, 1'b0);
    check(frameArmed == 1'b1, "R6 clear ignored", frameArmed, 1);
    cfgWrite(2'b00, 1'b0, 1'b1);
    check(frameArmed == 1'b1, "R6 clear ignored dir", frameArmed, 1);
    readByte(got);
    check(got == 8'h3C, "R6 byte intact", got, 8'h3C);

    // R8 disarm keeps partial bits
    sendBits(8'h05, 3);
    cfgWrite(2'b00, 1'b0, 1'b0);
    check(frameArmed == 1'b0, "R8 disarmed", frameArmed, 0);
    sendBits(8'h00, 2);
    check(readyDataN == 1'b1, "R8 no byte yet", readyDataN, 1);
    cfgWrite(2'b00, 1'b1, 1'b0);
    sendBits(8'h13, 5);
    check(readyDataN == 1'b0, "R8 byte ready", readyDataN, 0);
    readByte(got);
    check(got == 8'hB3, "R8 partial kept", got, 8'hB3);

    // R7 reinit discards partial bits
    sendBits(8'h07, 3);
    cfgWrite(2'b00, 1'b0, 1'b1);
    check(frameArmed == 1'b0, "R7 disarmed", frameArmed, 0);
    cfgWrite(2'b00, 1'b1, 1'b0);
    sendBits(8'h0A, 5);
    check(readyDataN == 1'b1, "R7 partial discarded", readyDataN, 1);
    sendBits(8'h03, 3);
    readByte(got);
    check(got == 8'h53, "R7 fresh byte", got, 8'h53);

    // R11 overrun
    sendBits(8'h81, 8);
    sendBits(8'h42, 8);
    check(overrun == 1'b1, "R11 overrun set", overrun, 1);
    check(sdo == 1'b0, "R11 restart at bit7", sdo, 0);
    readByte(got);
    check(got == 8'h42, "R11 newest byte kept", got, 8'h42);
    sendBits(8'hC6, 8);
    readByte(got);
    check(overrun == 1'b1, "R11 sticky", overrun, 1);
    cfgWrite(2'b00, 1'b0, 1'b1);
    check(overrun == 1'b0, "R7 overrun cleared", overrun, 0);

    // R9 raw mode
    cfgWrite(2'b10, 1'b0, 1'b0);
    prev = readyDataN;
    v = 8'b10110010;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); rxBit = v[i]; rxBitClk = 1'b1;
      repeat (3) @(negedge clk);
      check(bitClkOut == 1'b1, "R9 clock follows", bitClkOut, 1);
      check(readyDataN == prev, "R9 holds until fall", readyDataN, prev);
      rxBitClk = 1'b0;
      repeat (3) @(negedge clk);
      check(readyDataN == v[i], "R9 raw bit", readyDataN, v[i]);
      prev = v[i];
    end

    // R10 stop mode
    cfgWrite(2'b11, 1'b1, 1'b0);
    check(bitClkOe == 1'b0, "R10 oe low", bitClkOe, 0);
    sendBits(8'h00, 8);
    check(readyDataN == 1'b1, "R10 flag high", readyDataN, 1);
    cfgWrite(2'b00, 1'b1, 1'b0);
    check(readyDataN == 1'b1, "R10 nothing assembled", readyDataN, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule